// File: doc/BRIEF.md
# Keyed Configuration Port with Logical-Device Banking

This block is the configuration front end of a legacy peripheral controller. A host reaches it through two adjacent byte ports on a synchronous single-cycle bus: port 0 holds the register number (index) and port 1 reads or writes the register that the index names. The configuration space stays closed until the host writes a fixed key byte to the index port twice in a row. A different fixed byte written to the index port closes it again.

While the space is open, the block serves the low (global) part of the index space itself. One register selects the active logical device. Five read-only registers report a 16-bit device identifier, a revision byte and a 16-bit manufacturer identifier. Any index at or above a banking threshold goes to the selected logical device through a one-cycle read or write strobe, which carries the device number, the index and the data. A read returns the device's data in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is closed (`cfg_open` low), the logical device number (`ld_sel`) is 0x00, and the index register is 0x00. An index-port read made right after unlocking returns 0x00.
- R2: Two back-to-back index-port writes of the open key (default 0x87) open the space. `cfg_open` goes high in the cycle after the second write.
- R3: While the space is closed, an index-port write of any other byte restarts the key sequence, so a single key write must then be followed by two more. Data-port accesses do not affect the sequence.
- R4: While the space is closed, every read of either port returns 0xFF. Data-port writes change no state and raise no strobe. Index-port writes other than the key change no register.
- R5: While the space is open, an index-port write of the close key (default 0xAA) sets `cfg_open` low in the next cycle. It leaves the index register and the logical device number unchanged.
- R6: While the space is open, any other index-port write loads the index register, and an index-port read returns that value.
- R7: Index 0x07 is the logical device number. It can be read and written through the data port, and its value drives `ld_sel`.
- R8: The identification registers are read-only: 0x20 returns the device ID high byte, 0x21 the device ID low byte, 0x22 the revision, 0x23 the manufacturer ID high byte and 0x24 the manufacturer ID low byte. Writes to them are ignored.
- R9: Any other index below the banking threshold (default 0x30) reads 0x00, and writes to it are ignored.
- R10: With the space open and the index at or above the threshold, a data-port write raises `ld_wr` for that cycle, with `ld_idx` equal to the index and `ld_wdata` equal to the byte written. A data-port read raises `ld_rd` and returns `ld_rdata` in the same cycle.
- R11: `ld_wr` and `ld_rd` are never high together, and neither is high while the space is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read |
| cfg_open | output | 1 | Configuration space open |
| ld_sel | output | 8 | Selected logical device number |
| ld_idx | output | 8 | Index forwarded to the logical device |
| ld_wr | output | 1 | Write strobe to the logical device |
| ld_rd | output | 1 | Read strobe to the logical device |
| ld_wdata | output | 8 | Write data to the logical device |
| ld_rdata | input | 8 | Read data from the logical device |

## Verification
The bench sets the device ID to 0xC3A5, the manufacturer ID to 0x5E71 and the revision to 0x3C. None of these equals the defaults, and none of their bytes equals 0x00 or 0xFF, so a swapped byte, a swapped register or a missed decode shows up as a wrong value. The bench's stand-in logical device returns `ld_sel ^ ld_idx ^ 0x5A`, which makes every banked read depend on both the selected device and the index. Because the keys stay at their defaults, the bench can interleave wrong bytes, data accesses and repeated keys, and it can write the open key as an index while the space is open.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter logic [15:0] DEV_ID    = 16'h0001,
  parameter logic [15:0] MFR_ID    = 16'h0002,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [7:0]  KEY_OPEN  = 8'h87,
  parameter logic [7:0]  KEY_CLOSE = 8'hAA,
  parameter logic [7:0]  LDN_REG   = 8'h07,
  parameter logic [7:0]  ID_BASE   = 8'h20,
  parameter logic [7:0]  LD_BASE   = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cs,
  input  logic       bus_wr,
  input  logic       bus_port,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cfg_open,
  output logic [7:0] ld_sel,
  output logic [7:0] ld_idx,
  output logic       ld_wr,
  output logic       ld_rd,
  output logic [7:0] ld_wdata,
  input  logic [7:0] ld_rdata
);
  logic       open_q, key_seen_q;
  logic [7:0] idx_q, ldn_q, glob_rd;

  wire idx_wr  = bus_cs &  bus_wr & ~bus_port;
  wire data_wr = bus_cs &  bus_wr &  bus_port;
  wire data_rd = bus_cs & ~bus_wr &  bus_port;
  wire banked  = idx_q >= LD_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      key_seen_q <= 1'b0;
      idx_q      <= 8'h00;
      ldn_q      <= 8'h00;
    end else begin
      if (idx_wr) begin
        if (!open_q) begin
          if (bus_wdata == KEY_OPEN) begin
            open_q     <= key_seen_q;
            key_seen_q <= ~key_seen_q;
          end else begin
            key_seen_q <= 1'b0;
          end
        end else if (bus_wdata == KEY_CLOSE) begin
          open_q <= 1'b0;
        end else begin
          idx_q <= bus_wdata;
        end
      end
      if (data_wr && open_q && idx_q == LDN_REG)
        ldn_q <= bus_wdata;
    end
  end

  always_comb begin
    glob_rd = 8'h00;
    if (idx_q == LDN_REG)         glob_rd = ldn_q;
    else if (idx_q == ID_BASE)    glob_rd = DEV_ID[15:8];
    else if (idx_q == ID_BASE+1)  glob_rd = DEV_ID[7:0];
    else if (idx_q == ID_BASE+2)  glob_rd = REV_ID;
    else if (idx_q == ID_BASE+3)  glob_rd = MFR_ID[15:8];
    else if (idx_q == ID_BASE+4)  glob_rd = MFR_ID[7:0];
  end

  assign bus_rdata = !open_q   ? 8'hFF :
                     !bus_port ? idx_q :
                     banked    ? ld_rdata : glob_rd;

  assign cfg_open = open_q;
  assign ld_sel   = ldn_q;
  assign ld_idx   = idx_q;
  assign ld_wdata = bus_wdata;
  assign ld_wr    = data_wr & open_q & banked;
  assign ld_rd    = data_rd & open_q & banked;

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_wr && ld_rd));
  // R11
  strobe_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr || ld_rd) |-> cfg_open);
  // R2
  open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && !(idx_wr && bus_wdata == KEY_OPEN)) |=> !cfg_open);
  // R5
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && bus_wdata == KEY_CLOSE) |=> (!cfg_open && $stable(ld_sel) && $stable(ld_idx)));
  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(ld_sel) && $stable(ld_idx)));
  // R10
  strobe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr || ld_rd) |-> ld_idx >= LD_BASE);
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  localparam logic [15:0] DEV = 16'hC3A5;
  localparam logic [15:0] MFR = 16'h5E71;
  localparam logic [7:0]  REV = 8'h3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_cs = 0, bus_wr = 0, bus_port = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata, ld_sel, ld_idx, ld_wdata, ld_rdata;
  logic cfg_open, ld_wr, ld_rd;
  int total = 0, bad = 0;

  always #10 clk = ~clk;
  assign ld_rdata = ld_sel ^ ld_idx ^ 8'h5A;

  sio_cfg_port #(.DEV_ID(DEV), .MFR_ID(MFR), .REV_ID(REV)) i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_open(cfg_open), .ld_sel(ld_sel),
    .ld_idx(ld_idx), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata));

  bit m_open = 0;
  int m_cnt = 0;
  logic [7:0] m_idx = 0, m_ldn = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(bit port);
    if (!m_open) return 8'hFF;
    if (!port) return m_idx;
    if (m_idx >= 8'h30) return m_ldn ^ m_idx ^ 8'h5A;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return DEV[15:8];
      8'h21: return DEV[7:0];
      8'h22: return REV;
      8'h23: return MFR[15:8];
      8'h24: return MFR[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(bit cs, bit wr, bit port, logic [7:0] wd, string req);
    bit ew, er;
    @(negedge clk);
    bus_cs = cs; bus_wr = wr; bus_port = port; bus_wdata = wd;
    #5;
    ew = cs & wr & port & m_open & (m_idx >= 8'h30);
    er = cs & !wr & port & m_open & (m_idx >= 8'h30);
    chk(req, "cfg_open", cfg_open, m_open);
    chk(req, "ld_sel", ld_sel, m_ldn);
    chk(req, "ld_wr", ld_wr, ew);
    chk(req, "ld_rd", ld_rd, er);
    if (cs && !wr) chk(req, "rdata", bus_rdata, model_rd(port));
    if (ew) begin
      chk(req, "ld_idx", ld_idx, m_idx);
      chk(req, "ld_wdata", ld_wdata, wd);
    end
    if (cs && wr && !port) begin
      if (!m_open) begin
        if (wd == 8'h87) begin
          if (m_cnt == 1) begin m_open = 1; m_cnt = 0; end else m_cnt = 1;
        end else m_cnt = 0;
      end else if (wd == 8'hAA) m_open = 0;
      else m_idx = wd;
    end
    if (cs && wr && port && m_open && m_idx == 8'h07) m_ldn = wd;
  endtask

  task automatic unlock(string req);
    step(1, 1, 0, 8'h87, req);
    step(1, 1, 0, 8'h87, req);
  endtask

  task automatic rd_reg(logic [7:0] r, string req);
    step(1, 1, 0, r, req);
    step(1, 0, 1, 8'h00, req);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 8'h00, "R1");
    // R4: locked reads and writes
    step(1, 0, 0, 8'h00, "R4");
    step(1, 0, 1, 8'h00, "R4");
    step(1, 1, 1, 8'h55, "R4");
    step(1, 1, 0, 8'h07, "R4");
    // R3: broken sequences
    step(1, 1, 0, 8'h87, "R3");
    step(1, 1, 0, 8'h86, "R3");
    step(1, 1, 0, 8'h87, "R3");
    step(1, 0, 1, 8'h00, "R3");
    step(1, 1, 1, 8'h11, "R3");
    step(1, 1, 0, 8'h87, "R3");
    // R1: index read after unlock
    step(1, 0, 0, 8'h00, "R1");
    step(1, 0, 1, 8'h00, "R1");
    // R8 identification
    for (int r = 8'h20; r <= 8'h24; r++) rd_reg(8'(r), "R8");
    step(1, 1, 0, 8'h21, "R8");
    step(1, 1, 1, 8'h00, "R8");
    step(1, 0, 1, 8'h00, "R8");
    // R9 unused globals
    rd_reg(8'h2F, "R9");
    step(1, 1, 1, 8'h77, "R9");
    step(1, 0, 1, 8'h00, "R9");
    rd_reg(8'h00, "R9");
    // R7 ldn
    rd_reg(8'h07, "R7");
    step(1, 1, 1, 8'h06, "R7");
    step(1, 0, 1, 8'h00, "R7");
    // R10 banked access
    step(1, 1, 0, 8'hF0, "R10");
    step(1, 1, 1, 8'hC4, "R10");
    step(1, 0, 1, 8'h00, "R10");
    step(1, 1, 0, 8'h30, "R10");
    step(1, 1, 1, 8'h01, "R10");
    step(1, 0, 1, 8'h00, "R10");
    // R6: open key as index while open
    step(1, 1, 0, 8'h87, "R6");
    step(1, 0, 0, 8'h00, "R6");
    step(1, 0, 1, 8'h00, "R6");
    step(1, 1, 0, 8'h07, "R6");
    step(1, 1, 1, 8'h03, "R7");
    step(1, 1, 0, 8'hE8, "R6");
    step(1, 0, 1, 8'h00, "R10");
    // R5 close
    step(1, 1, 0, 8'hAA, "R5");
    step(1, 0, 1, 8'h00, "R5");
    step(1, 1, 1, 8'h99, "R11");
    step(1, 0, 0, 8'h00, "R4");
    unlock("R2");
    step(1, 0, 0, 8'h00, "R5");
    step(1, 0, 1, 8'h00, "R5");
    step(1, 1, 0, 8'hAA, "R5");
    step(0, 0, 0, 8'h00, "R5");
    // R2: triple key opens after second
    step(1, 1, 0, 8'h87, "R2");
    step(1, 1, 0, 8'h87, "R2");
    step(1, 1, 0, 8'h87, "R2");
    step(1, 0, 0, 8'h00, "R2");
    // R1: reset clears state
    @(negedge clk); rst_n = 0; bus_cs = 0;
    @(negedge clk); rst_n = 1;
    m_open = 0; m_cnt = 0; m_idx = 0; m_ldn = 0;
    step(0, 0, 0, 8'h00, "R1");
    unlock("R1");
    step(1, 0, 0, 8'h00, "R1");
    rd_reg(8'h07, "R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule